// File: doc/BRIEF.md
# Interruption Entry Sequencer

This block carries out the architectural state save and redirect that a processor performs when it takes an interruption. The pipeline stalls and presents an exception code together with its current status word, the front and back instruction offset queues, the 64-bit front and back space queues, the vector base register, the general register file and, for decoder-detected traps, the instruction word the decoder already holds. The block copies all of these on the start cycle and then works through a fixed sequence.

The sequence first saves the old status word. It then loads a fresh status word and records both queues in the interruption queue registers. When the old status word had its Q bit set, two more steps follow. The first records the faulting instruction word, chosen by the exception's class. The second copies seven general registers into shadow registers. The last step computes the handler's entry point: a 32-byte slot per exception code, counted from the vector base. For some classes the instruction word has to be fetched again. The block does this through a valid/ready request port and a response port that can report a failed translation. A busy flag holds the pipeline while the sequence runs, and a one-cycle done pulse marks the point where every output register holds its final value.

Top module: `ies_entry_seq`

## Requirements
- R1: A start pulse is accepted only while the block is idle. The interrupted-status output then takes the status word present on that start cycle.
- R2: The new status word has only bit 27 (wide mode) set. When the exception code is 1 (high-priority machine check), bit 11 (machine-check mask) is also set.
- R3: The interruption space queue outputs take bits 63:32 of the front and back space queues. The interruption offset queue outputs take the front and back offsets unchanged.
- R4: When bit 3 (Q) of the old status word is clear, the instruction word and all shadow registers keep their previous values, and no fetch is requested.
- R5: When Q is set, shadow slots 0 through 6 receive general registers 1, 8, 9, 16, 17, 24 and 25 respectively.
- R6: When Q is set and the code is in 12..22 or 26..28 (fetch class), a fetch is requested at the front offset with bits 1:0 cleared. The instruction word becomes the returned data.
- R7: When the old status word has bit 18 (translation) set and the fetch response reports a translation failure, the instruction word becomes 0. The failure flag is ignored when bit 18 is clear. A fetch request holds its address until it is accepted.
- R8: When Q is set and the code is in 8..11 (decoder class), the instruction word becomes the decoder-supplied word. Any other code outside the fetch class leaves the instruction word unchanged.
- R9: The new front offset is the vector base plus 32 times the code, modulo 2^32. The new back offset is the front plus 4, and both new space queues are zero.
- R10: After reset, busy and done are low and every output register is zero. Busy is high from the cycle after an accepted start until the sequence ends, then done pulses for one cycle with busy low.
- R11: A start pulse that arrives while busy is ignored and produces no second done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an interruption entry |
| code_i | input | 6 | Exception code |
| psw_i | input | 32 | Current status word |
| iaoq_f_i | input | 32 | Front instruction offset |
| iaoq_b_i | input | 32 | Back instruction offset |
| iasq_f_i | input | 64 | Front space queue |
| iasq_b_i | input | 64 | Back space queue |
| iva_i | input | 32 | Vector base |
| gr_i | input | 1024 | General register file, register n at bits 32n+31:32n |
| dec_iir_i | input | 32 | Instruction word supplied by the decoder |
| if_req_valid_o | output | 1 | Fetch request valid |
| if_req_ready_i | input | 1 | Fetch request accepted |
| if_req_addr_o | output | 32 | Fetch address |
| if_req_xlate_o | output | 1 | Fetch uses translation |
| if_rsp_valid_i | input | 1 | Fetch response valid |
| if_rsp_data_i | input | 32 | Fetched word |
| if_rsp_xfail_i | input | 1 | Translation failed |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete (one cycle) |
| ipsw_o | output | 32 | Interrupted status word |
| psw_o | output | 32 | New status word |
| iiasq_f_o | output | 32 | Saved front space (upper half) |
| iiasq_b_o | output | 32 | Saved back space (upper half) |
| iiaoq_f_o | output | 32 | Saved front offset |
| iiaoq_b_o | output | 32 | Saved back offset |
| iir_o | output | 32 | Recorded instruction word |
| shadow_o | output | 224 | Shadow registers, slot k at bits 32k+31:32k |
| iaoq_f_o | output | 32 | New front offset |
| iaoq_b_o | output | 32 | New back offset |
| iasq_f_o | output | 64 | New front space |
| iasq_b_o | output | 64 | New back space |

## Verification
The entry sequence is driven with the Q bit clear and set across codes from each class: the machine-check code, a decoder-class code, fetch-class codes and an unclassified code. This separates the status-word rule from the capture rule, and the capture rule from the shadow save. Fetch-class cases are run with translation on and off against a response that reports failure, and then with translation on and no failure. These cases show whether the failure flag is qualified by the old status word. Each fetched word is a function of its address, so a wrong alignment shows up in the instruction word. A wrapping vector base with the largest code, a slow request acceptance and a second start while busy cover the arithmetic edge, the held request and the ignored start.

// File: rtl/ies_pkg.sv
package ies_pkg;

  localparam int XLEN     = 32;
  localparam int SPW      = 2 * XLEN;
  localparam int EXC_W    = 6;
  localparam int N_SHADOW = 7;
  localparam int VEC_SH   = 5;

  localparam int PSW_Q = 3;
  localparam int PSW_M = 11;
  localparam int PSW_C = 18;
  localparam int PSW_W = 27;

  localparam logic [EXC_W-1:0] CODE_HPMC = 6'd1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SAVE, ST_CAPT, ST_FREQ, ST_FRSP, ST_SHAD, ST_VECT, ST_FIN
  } seq_state_t;

  typedef enum logic [1:0] { CAP_NONE, CAP_DEC, CAP_FETCH } iir_src_t;

  function automatic iir_src_t classify(input logic [EXC_W-1:0] c);
    if (c inside {[6'd8:6'd11]})                   return CAP_DEC;
    if (c inside {[6'd12:6'd22], [6'd26:6'd28]})   return CAP_FETCH;
    return CAP_NONE;
  endfunction

  function automatic logic [XLEN-1:0] entry_psw(input logic [EXC_W-1:0] c);
    logic [XLEN-1:0] p;
    p = '0;
    p[PSW_W] = 1'b1;
    p[PSW_M] = (c == CODE_HPMC);
    return p;
  endfunction

  function automatic logic [XLEN-1:0] vector_of(input logic [XLEN-1:0] base,
                                                input logic [EXC_W-1:0] c);
    logic [XLEN-1:0] ext;
    ext = XLEN'(c);
    return base + (ext << VEC_SH);
  endfunction

  // Shadow slot k draws from register 1, 8, 9, 16, 17, 24, 25 for k = 0..6.
  function automatic int shadow_src(input int k);
    if (k == 0) return 1;
    if (k % 2 == 1) return 8 * ((k + 1) / 2);
    return 8 * (k / 2) + 1;
  endfunction

endpackage

// File: rtl/ies_classify.sv
module ies_classify
  import ies_pkg::*;
(
  input  logic [EXC_W-1:0] code_i,
  output iir_src_t         src_o,
  output logic             hpmc_o
);
  always_comb begin
    src_o  = classify(code_i);
    hpmc_o = (code_i == CODE_HPMC);
  end
endmodule

// File: rtl/ies_shadow_pick.sv
module ies_shadow_pick
  import ies_pkg::*;
#(
  parameter int NUM_GR = 32
) (
  input  logic [NUM_GR*XLEN-1:0]   gr_i,
  output logic [N_SHADOW*XLEN-1:0] pick_o
);
  localparam int MAX_SRC = shadow_src(N_SHADOW - 1);

  initial begin
    if (NUM_GR <= MAX_SRC) $error("register file too small for shadow set");
  end

  for (genvar k = 0; k < N_SHADOW; k++) begin : g_slot
    localparam int SRC = shadow_src(k);
    assign pick_o[k*XLEN +: XLEN] = gr_i[SRC*XLEN +: XLEN];
  end

  logic unused_gr;
  assign unused_gr = ^gr_i;
endmodule

// File: rtl/ies_fsm.sv
module ies_fsm
  import ies_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       q_set_i,
  input  iir_src_t   src_i,
  input  logic       req_ready_i,
  input  logic       rsp_valid_i,
  output seq_state_t state_o
);
  seq_state_t st, nx;

  always_comb begin
    nx = st;
    unique case (st)
      ST_IDLE: if (start_i) nx = ST_SAVE;
      ST_SAVE: begin
        if (!q_set_i)                nx = ST_VECT;
        else if (src_i == CAP_FETCH) nx = ST_FREQ;
        else                         nx = ST_CAPT;
      end
      ST_CAPT: nx = ST_SHAD;
      ST_FREQ: if (req_ready_i) nx = ST_FRSP;
      ST_FRSP: if (rsp_valid_i) nx = ST_SHAD;
      ST_SHAD: nx = ST_VECT;
      ST_VECT: nx = ST_FIN;
      ST_FIN:  nx = ST_IDLE;
      default: nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nx;
  end

  assign state_o = st;

  a_r6_rsp_to_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FRSP && rsp_valid_i) |=> (st == ST_SHAD));
  a_r4_noq_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SAVE && !q_set_i) |=> (st == ST_VECT));
endmodule

// File: rtl/ies_entry_seq.sv
module ies_entry_seq
  import ies_pkg::*;
#(
  parameter int NUM_GR = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [EXC_W-1:0]         code_i,
  input  logic [XLEN-1:0]          psw_i,
  input  logic [XLEN-1:0]          iaoq_f_i,
  input  logic [XLEN-1:0]          iaoq_b_i,
  input  logic [SPW-1:0]           iasq_f_i,
  input  logic [SPW-1:0]           iasq_b_i,
  input  logic [XLEN-1:0]          iva_i,
  input  logic [NUM_GR*XLEN-1:0]   gr_i,
  input  logic [XLEN-1:0]          dec_iir_i,
  output logic                     if_req_valid_o,
  input  logic                     if_req_ready_i,
  output logic [XLEN-1:0]          if_req_addr_o,
  output logic                     if_req_xlate_o,
  input  logic                     if_rsp_valid_i,
  input  logic [XLEN-1:0]          if_rsp_data_i,
  input  logic                     if_rsp_xfail_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [XLEN-1:0]          ipsw_o,
  output logic [XLEN-1:0]          psw_o,
  output logic [XLEN-1:0]          iiasq_f_o,
  output logic [XLEN-1:0]          iiasq_b_o,
  output logic [XLEN-1:0]          iiaoq_f_o,
  output logic [XLEN-1:0]          iiaoq_b_o,
  output logic [XLEN-1:0]          iir_o,
  output logic [N_SHADOW*XLEN-1:0] shadow_o,
  output logic [XLEN-1:0]          iaoq_f_o,
  output logic [XLEN-1:0]          iaoq_b_o,
  output logic [SPW-1:0]           iasq_f_o,
  output logic [SPW-1:0]           iasq_b_o
);
  localparam int HALF = SPW / 2;

  // Snapshot taken on the accepted start cycle
  logic [EXC_W-1:0]         s_code;
  logic [XLEN-1:0]          s_psw, s_iaoq_f, s_iaoq_b, s_iva, s_dec;
  logic [HALF-1:0]          s_iasq_f_hi, s_iasq_b_hi;
  logic [N_SHADOW*XLEN-1:0] s_shadow;

  seq_state_t               st;
  iir_src_t                 src;
  logic                     is_hpmc;
  logic [N_SHADOW*XLEN-1:0] picked;

  // Named internal events
  logic accept_evt, save_evt, capt_evt, fetch_ret_evt, shad_evt, vect_evt;
  logic [XLEN-1:0] vec_addr;
  logic [XLEN-1:0] fetched_word;

  ies_classify u_class (
    .code_i (s_code),
    .src_o  (src),
    .hpmc_o (is_hpmc)
  );

  ies_shadow_pick #(.NUM_GR(NUM_GR)) u_pick (
    .gr_i   (gr_i),
    .pick_o (picked)
  );

  ies_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .q_set_i     (s_psw[PSW_Q]),
    .src_i       (src),
    .req_ready_i (if_req_ready_i),
    .rsp_valid_i (if_rsp_valid_i),
    .state_o     (st)
  );

  assign accept_evt    = start_i && (st == ST_IDLE);
  assign save_evt      = (st == ST_SAVE);
  assign capt_evt      = (st == ST_CAPT) && (src == CAP_DEC);
  assign fetch_ret_evt = (st == ST_FRSP) && if_rsp_valid_i;
  assign shad_evt      = (st == ST_SHAD);
  assign vect_evt      = (st == ST_VECT);
  assign vec_addr      = vector_of(s_iva, s_code);
  assign fetched_word  = (s_psw[PSW_C] && if_rsp_xfail_i) ? '0 : if_rsp_data_i;

  assign if_req_valid_o = (st == ST_FREQ);
  assign if_req_addr_o  = {s_iaoq_f[XLEN-1:2], 2'b00};
  assign if_req_xlate_o = s_psw[PSW_C];
  assign busy_o         = (st != ST_IDLE) && (st != ST_FIN);
  assign done_o         = (st == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_code      <= '0;
      s_psw       <= '0;
      s_iaoq_f    <= '0;
      s_iaoq_b    <= '0;
      s_iva       <= '0;
      s_dec       <= '0;
      s_iasq_f_hi <= '0;
      s_iasq_b_hi <= '0;
      s_shadow    <= '0;
    end else if (accept_evt) begin
      s_code      <= code_i;
      s_psw       <= psw_i;
      s_iaoq_f    <= iaoq_f_i;
      s_iaoq_b    <= iaoq_b_i;
      s_iva       <= iva_i;
      s_dec       <= dec_iir_i;
      s_iasq_f_hi <= iasq_f_i[SPW-1:HALF];
      s_iasq_b_hi <= iasq_b_i[SPW-1:HALF];
      s_shadow    <= picked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipsw_o    <= '0;
      psw_o     <= '0;
      iiasq_f_o <= '0;
      iiasq_b_o <= '0;
      iiaoq_f_o <= '0;
      iiaoq_b_o <= '0;
    end else if (save_evt) begin
      ipsw_o    <= s_psw;
      psw_o     <= entry_psw(s_code);
      iiasq_f_o <= s_iasq_f_hi;
      iiasq_b_o <= s_iasq_b_hi;
      iiaoq_f_o <= s_iaoq_f;
      iiaoq_b_o <= s_iaoq_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             iir_o <= '0;
    else if (capt_evt)      iir_o <= s_dec;
    else if (fetch_ret_evt) iir_o <= fetched_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shadow_o <= '0;
    else if (shad_evt) shadow_o <= s_shadow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iaoq_f_o <= '0;
      iaoq_b_o <= '0;
      iasq_f_o <= '0;
      iasq_b_o <= '0;
    end else if (vect_evt) begin
      iaoq_f_o <= vec_addr;
      iaoq_b_o <= vec_addr + XLEN'(4);
      iasq_f_o <= '0;
      iasq_b_o <= '0;
    end
  end

  logic unused_misc;
  assign unused_misc = ^{iasq_f_i[HALF-1:0], iasq_b_i[HALF-1:0], is_hpmc};

  // Assertions
  a_r1_ipsw_capture: assert property (@(posedge clk) disable iff (!rst_n)
    save_evt |=> (ipsw_o == $past(s_psw)));
  a_r2_psw_wide: assert property (@(posedge clk) disable iff (!rst_n)
    save_evt |=> (psw_o[PSW_W] && $countones(psw_o) <= 2));
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req_valid_o && !if_req_ready_i) |=> (if_req_valid_o && $stable(if_req_addr_o)));
  a_r9_vector_slot: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((iaoq_b_o == iaoq_f_o + XLEN'(4)) &&
                (iaoq_f_o[VEC_SH-1:0] == s_iva[VEC_SH-1:0])));
  a_r10_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, done_o}));
  a_r11_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (st != ST_IDLE && st != ST_SAVE));
endmodule

// File: tb/ies_entry_seq_tb.sv
module ies_entry_seq_tb;
  localparam int XL = 32;
  localparam int NG = 32;

  typedef struct {
    logic [31:0] ipsw, psw, iiasq_f, iiasq_b, iiaoq_f, iiaoq_b, iir;
    logic [223:0] shadow;
    logic [31:0] iaoq_f, iaoq_b;
    logic [63:0] iasq_f, iasq_b;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 0;
  logic [5:0] code = 0;
  logic [31:0] psw = 0, iaoq_f = 0, iaoq_b = 0, iva = 0, dec = 0;
  logic [63:0] iasq_f = 0, iasq_b = 0;
  logic [NG*XL-1:0] gr = '0;
  logic req_valid, req_ready = 0, req_xlate, rsp_valid = 0, rsp_xfail = 0;
  logic [31:0] req_addr, rsp_data = 0;
  logic busy, done;
  logic [31:0] ipsw_o, psw_o, iiasq_f_o, iiasq_b_o, iiaoq_f_o, iiaoq_b_o, iir_o;
  logic [223:0] shadow_o;
  logic [31:0] iaoq_f_o, iaoq_b_o;
  logic [63:0] iasq_f_o, iasq_b_o;

  ies_entry_seq #(.NUM_GR(NG)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .code_i(code), .psw_i(psw),
    .iaoq_f_i(iaoq_f), .iaoq_b_i(iaoq_b), .iasq_f_i(iasq_f), .iasq_b_i(iasq_b),
    .iva_i(iva), .gr_i(gr), .dec_iir_i(dec),
    .if_req_valid_o(req_valid), .if_req_ready_i(req_ready), .if_req_addr_o(req_addr),
    .if_req_xlate_o(req_xlate), .if_rsp_valid_i(rsp_valid), .if_rsp_data_i(rsp_data),
    .if_rsp_xfail_i(rsp_xfail), .busy_o(busy), .done_o(done),
    .ipsw_o(ipsw_o), .psw_o(psw_o), .iiasq_f_o(iiasq_f_o), .iiasq_b_o(iiasq_b_o),
    .iiaoq_f_o(iiaoq_f_o), .iiaoq_b_o(iiaoq_b_o), .iir_o(iir_o), .shadow_o(shadow_o),
    .iaoq_f_o(iaoq_f_o), .iaoq_b_o(iaoq_b_o), .iasq_f_o(iasq_f_o), .iasq_b_o(iasq_b_o)
  );

  int checks = 0, errors = 0;
  exp_t sb[$];
  logic [31:0] model_iir = 0;
  logic [223:0] model_shadow = '0;
  int ready_delay = 0;
  int fetch_count = 0;
  logic [31:0] last_fetch_addr = 0;

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a ^ 32'h1234_5678) + 32'h0000_0101;
  endfunction

  // Fetch responder
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        last_fetch_addr = req_addr;
        repeat (ready_delay) @(negedge clk);
        req_ready = 1;
        @(negedge clk);
        req_ready = 0;
        rsp_valid = 1;
        rsp_data  = mem_word(last_fetch_addr);
        @(negedge clk);
        rsp_valid = 0;
        fetch_count++;
      end
    end
  end

  // Monitor: pop expected items on done
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk("R11", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk("R1", "ipsw", ipsw_o, e.ipsw);
        chk("R2", "psw", psw_o, e.psw);
        chk("R3", "iiasq_f", iiasq_f_o, e.iiasq_f);
        chk("R3", "iiasq_b", iiasq_b_o, e.iiasq_b);
        chk("R3", "iiaoq_f", iiaoq_f_o, e.iiaoq_f);
        chk("R3", "iiaoq_b", iiaoq_b_o, e.iiaoq_b);
        chk("R4/R6/R7/R8", "iir", iir_o, e.iir);
        for (int k = 0; k < 7; k++)
          chk("R4/R5", $sformatf("shadow%0d", k), shadow_o[k*32 +: 32], e.shadow[k*32 +: 32]);
        chk("R9", "iaoq_f", iaoq_f_o, e.iaoq_f);
        chk("R9", "iaoq_b", iaoq_b_o, e.iaoq_b);
        chk("R9", "iasq_f", iasq_f_o, e.iasq_f);
        chk("R9", "iasq_b", iasq_b_o, e.iasq_b);
        chk("R10", "busy during done", busy, 0);
      end
    end
  end

  task automatic run_case(logic [5:0] c, logic [31:0] p, logic [31:0] of, logic [31:0] ob,
                          logic [63:0] sf, logic [63:0] sbk, logic [31:0] base,
                          logic [31:0] d, logic [31:0] seed, logic xf, int dly,
                          bit poke_busy);
    exp_t e;
    bit q, xl, fcls, dcls;
    int src[7] = '{1, 8, 9, 16, 17, 24, 25};
    int fc0;
    bit seen;
    for (int i = 0; i < NG; i++) gr[i*32 +: 32] = seed + i * 32'h0101_0101;
    q    = p[3];
    xl   = p[18];
    fcls = (c >= 12 && c <= 22) || (c >= 26 && c <= 28);
    dcls = (c >= 8 && c <= 11);
    e.ipsw = p;
    e.psw = 32'h0800_0000 | ((c == 6'd1) ? 32'h0000_0800 : 32'h0);
    e.iiasq_f = sf[63:32];
    e.iiasq_b = sbk[63:32];
    e.iiaoq_f = of;
    e.iiaoq_b = ob;
    if (q) begin
      if (fcls) model_iir = (xl && xf) ? 32'h0 : mem_word({of[31:2], 2'b00});
      else if (dcls) model_iir = d;
      for (int k = 0; k < 7; k++) model_shadow[k*32 +: 32] = gr[src[k]*32 +: 32];
    end
    e.iir = model_iir;
    e.shadow = model_shadow;
    e.iaoq_f = base + {20'h0, c, 6'h0} / 2;
    e.iaoq_b = e.iaoq_f + 32'd4;
    e.iasq_f = 64'h0;
    e.iasq_b = 64'h0;
    sb.push_back(e);
    ready_delay = dly;
    rsp_xfail = xf;
    fc0 = fetch_count;

    @(negedge clk);
    start = 1; code = c; psw = p; iaoq_f = of; iaoq_b = ob;
    iasq_f = sf; iasq_b = sbk; iva = base; dec = d;
    @(negedge clk);
    start = 0;
    code = ~c; psw = ~p; iaoq_f = ~of; iva = ~base; dec = ~d;
    gr = ~gr;
    chk("R10", "busy after start", busy, 1);
    if (poke_busy) begin
      @(negedge clk);
      start = 1; code = 6'd2;
      @(negedge clk);
      start = 0;
    end
    seen = 0;
    for (int n = 0; n < 40 && !seen; n++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    if (!seen) chk("R10", "watchdog no done", 0, 1);
    repeat (4) @(negedge clk);
    if (poke_busy) chk("R11", "queue drained", sb.size(), 0);
    chk("R4/R6", "fetch count", fetch_count - fc0, (q && fcls) ? 1 : 0);
    if (q && fcls) begin
      chk("R6", "fetch addr", last_fetch_addr, {of[31:2], 2'b00});
    end
    chk("R10", "idle after", busy, 0);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    chk("R10", "global watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset done", done, 0);
    chk("R10", "reset ipsw", ipsw_o, 0);
    chk("R10", "reset iir", iir_o, 0);
    chk("R10", "reset iaoq_f", iaoq_f_o, 0);
    rst_n = 1;
    @(negedge clk);
    // code, psw, of, ob, sf, sb, base, dec, seed, xfail, delay, poke
    run_case(6'd4,  32'h0000_0000, 32'h0000_1003, 32'h0000_1007,
             64'hAAAA_0001_1111_2222, 64'hBBBB_0002_3333_4444, 32'h0010_0000,
             32'hDEAD_0001, 32'h1000_0000, 0, 0, 0);
    run_case(6'd1,  32'h0000_0008, 32'h0000_2000, 32'h0000_2004,
             64'h1234_5678_0000_0000, 64'h8765_4321_FFFF_FFFF, 32'h0020_0000,
             32'hDEAD_0002, 32'h2000_0000, 0, 0, 0);
    run_case(6'd9,  32'h0004_0008, 32'h0000_3001, 32'h0000_3005,
             64'h0, 64'h1, 32'h0030_0000, 32'hCAFE_0009, 32'h3000_0000, 1, 0, 0);
    run_case(6'd12, 32'h0000_0008, 32'h0000_4003, 32'h0000_4007,
             64'h0000_0001_0000_0000, 64'h0000_0002_0000_0000, 32'h0040_0000,
             32'hDEAD_000C, 32'h4000_0000, 1, 1, 0);
    run_case(6'd27, 32'h0004_0008, 32'h0000_5002, 32'h0000_5006,
             64'h5, 64'h6, 32'h0050_0000, 32'hDEAD_001B, 32'h5000_0000, 1, 3, 0);
    run_case(6'd15, 32'h0004_0008, 32'h8000_6001, 32'h8000_6005,
             64'hFFFF_FFFF_0000_0000, 64'h7, 32'h0060_0000, 32'hDEAD_000F,
             32'h6000_0000, 0, 0, 0);
    run_case(6'd10, 32'h0004_0000, 32'h0000_7000, 32'h0000_7004,
             64'h9, 64'hA, 32'h0070_0000, 32'hBEEF_000A, 32'h7000_0000, 0, 0, 0);
    run_case(6'd63, 32'hFFFF_FFFF, 32'h0000_8000, 32'h0000_8004,
             64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 32'hFFFF_FF00,
             32'hDEAD_003F, 32'h8000_0000, 0, 0, 1);
    repeat (3) @(negedge clk);
    chk("R11", "scoreboard empty", sb.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule